// File: doc/BRIEF.md
# Per-Port Transmit Jabber Watchdog

This block guards a small group of station transmit ports that share one network segment. For each port it times how long the transmit-active flag stays high without a break. When a port stays active for longer than the activation window, the block takes that port off the network by dropping its enable. At the same time it raises a collision request toward the port so the station backs off, and it lights an active-low jabber indicator.

A cut-off port is held off until its transmit flag has been low for an unbroken unjab window. Any renewed activity during that window restarts the quiet count. A single global disable input turns off the whole function for every port.

All timing is counted in ticks from a shared prescaler. With the default parameters a 200 MHz clock gives a 1 ms tick, an activation window of 14 ticks and an unjab window of 450 ticks. Detection of activity on the line is outside this block: it only sees a clean, synchronous transmit-active flag for each port.

Top module: `jabwd_top`

## Requirements
- R1: While reset is high and on the first edge after it, every port reports enable = 1, collision request = 0 and indicator = 1 (indicator is active low).
- R2: The prescaler produces one tick every CLKS_PER_TICK clocks. The port logic first sees a tick at the (CLKS_PER_TICK+1)-th rising edge after reset is released, and then at every CLKS_PER_TICK-th edge after that.
- R3: An idle port whose flag is seen high starts timing on that edge. If the flag stays high, the port is cut off (enable = 0) on the edge at which the ACT_TICKS-th tick after that starting edge is seen.
- R4: A flag that drops before the cut-off sends the port back to idle with its count cleared. Bursts shorter than (ACT_TICKS-1)*CLKS_PER_TICK+1 clocks, separated by at least one idle clock, never cut a port off.
- R5: While a port is cut off, its enable is 0, its collision request is 1 and its indicator is 0. All three change together, on the same edge.
- R6: A cut-off port is released once UNJAB_TICKS ticks have been seen with its flag low and no high flag in between. Any clock with the flag high restarts this count from zero.
- R7: While the global disable input is high, no port starts timing. Any port that is timing or cut off returns to idle, and is enabled from the next edge.
- R8: Each port is timed on its own. Activity on, or the cut-off of, one port never changes another port's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_active_i | input | NUM_PORTS | Per-port transmit-active flag |
| jab_disable_i | input | 1 | Global disable of the jabber function |
| port_en_o | output | NUM_PORTS | Per-port transmit enable toward the network |
| col_req_o | output | NUM_PORTS | Per-port collision request toward the station |
| jab_led_n_o | output | NUM_PORTS | Per-port active-low jabber indicator |

## Verification
A wrong internal state shows up directly on the enable of the affected port.

- A tick counter with the wrong phase moves the cut-off edge by whole clocks.
- A count that is not cleared after a short burst cuts off a port that should have stayed enabled.
- A quiet count that is not restarted by activity releases the port early. This shows within one unjab window.

A reference model of the tick phase and the three states per port predicts every output on every clock. Sweeps of the start phase pin the cut-off edge to the exact cycle.

// File: rtl/jabwd_pkg.sv
package jabwd_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_TIMING = 2'd1,
    PS_JABBED = 2'd2
  } port_state_t;
endpackage

// File: rtl/jabwd_tick.sv
module jabwd_tick #(
  parameter int CLKS_PER_TICK = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (CLKS_PER_TICK > 1) begin : g_div
      localparam int TW = $clog2(CLKS_PER_TICK);
      localparam logic [TW-1:0] LAST = TW'(CLKS_PER_TICK - 1);
      logic [TW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          tick_o <= 1'b0;
        end else begin
          cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + TW'(1);
          tick_o <= (cnt_q == LAST);
        end
      end

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R2
      AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R2
    end else begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick_o <= 1'b0;
        else     tick_o <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/jabwd_port.sv
module jabwd_port
  import jabwd_pkg::*;
#(
  parameter int ACT_TICKS   = 14,
  parameter int UNJAB_TICKS = 450
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic jab_off_i,
  input  logic tx_active_i,
  output logic port_en_o,
  output logic col_req_o,
  output logic jab_led_n_o
);
  localparam int MAXT = (ACT_TICKS > UNJAB_TICKS) ? ACT_TICKS : UNJAB_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ACT_LAST   = CW'(ACT_TICKS);
  localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_TICKS);

  port_state_t   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (jab_off_i) begin
      st_d  = PS_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PS_IDLE: begin
          cnt_d = '0;
          if (tx_active_i) st_d = PS_TIMING;
        end
        PS_TIMING: begin
          if (!tx_active_i) begin
            st_d  = PS_IDLE;
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_inc == ACT_LAST) begin
              st_d  = PS_JABBED;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
        PS_JABBED: begin
          if (tx_active_i) begin
            cnt_d = '0;
          end else if (tick_i) begin
            if (cnt_inc == UNJAB_LAST) begin
              st_d  = PS_IDLE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_inc;
            end
          end
        end
        default: begin
          st_d  = PS_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PS_IDLE;
      cnt_q       <= '0;
      port_en_o   <= 1'b1;
      col_req_o   <= 1'b0;
      jab_led_n_o <= 1'b1;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      port_en_o   <= (st_d != PS_JABBED);
      col_req_o   <= (st_d == PS_JABBED);
      jab_led_n_o <= (st_d != PS_JABBED);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(MAXT)); // R3
  AST_COL_WITH_OFF: assert property (@(posedge clk) disable iff (rst)
    col_req_o == !port_en_o); // R5
  AST_LED_WITH_OFF: assert property (@(posedge clk) disable iff (rst)
    jab_led_n_o == port_en_o); // R5
  AST_CUT_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    $fell(port_en_o) |-> $past(tx_active_i)); // R3
  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (!port_en_o && tx_active_i && !jab_off_i) |=> !port_en_o); // R6
  AST_CUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(port_en_o) |-> $past(tick_i)); // R2
endmodule

// File: rtl/jabwd_top.sv
module jabwd_top #(
  parameter int NUM_PORTS     = 2,
  parameter int CLKS_PER_TICK = 200000,
  parameter int ACT_TICKS     = 14,
  parameter int UNJAB_TICKS   = 450
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] tx_active_i,
  input  logic                 jab_disable_i,
  output logic [NUM_PORTS-1:0] port_en_o,
  output logic [NUM_PORTS-1:0] col_req_o,
  output logic [NUM_PORTS-1:0] jab_led_n_o
);
  logic tick;

  jabwd_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) i_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    jabwd_port #(
      .ACT_TICKS   (ACT_TICKS),
      .UNJAB_TICKS (UNJAB_TICKS)
    ) i_port (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (tick),
      .jab_off_i   (jab_disable_i),
      .tx_active_i (tx_active_i[p]),
      .port_en_o   (port_en_o[p]),
      .col_req_o   (col_req_o[p]),
      .jab_led_n_o (jab_led_n_o[p])
    );

    AST_QUIET_NO_CUT: assert property (@(posedge clk) disable iff (rst)
      (port_en_o[p] && !tx_active_i[p]) |=> port_en_o[p]); // R8
  end

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    jab_disable_i |=> (&port_en_o)); // R7
endmodule

// File: tb/test_jabwd_top.sv
`timescale 1ns/1ps
module test_jabwd_top;
  localparam int NP = 2;
  localparam int P  = 4;
  localparam int AT = 3;
  localparam int UT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] tx = '0;
  logic dis = 1'b0;
  logic [NP-1:0] en, col, led_n;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  bit chk_on = 1'b0;
  int mst  [NP];
  int mcnt [NP];
  int mprev[NP];

  always #2.5 clk = ~clk;

  jabwd_top #(.NUM_PORTS(NP), .CLKS_PER_TICK(P), .ACT_TICKS(AT), .UNJAB_TICKS(UT)) i_jabwd_top (
    .clk(clk), .rst(rst), .tx_active_i(tx), .jab_disable_i(dis),
    .port_en_o(en), .col_req_o(col), .jab_led_n_o(led_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, k);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Reference model built from R2, R3, R4, R6 and R7.
  always @(posedge clk) begin
    bit tk;
    if (rst) k = 0; else k = k + 1;
    tk = !rst && (k - 1 >= 1) && ((k - 1) % P == 0);
    for (int p = 0; p < NP; p++) begin
      mprev[p] = mst[p];
      if (rst || dis) begin
        mst[p] = 0; mcnt[p] = 0;
      end else if (mst[p] == 0) begin
        if (tx[p]) mst[p] = 1;
        mcnt[p] = 0;
      end else if (mst[p] == 1) begin
        if (!tx[p]) begin mst[p] = 0; mcnt[p] = 0; end
        else if (tk) begin
          if (mcnt[p] + 1 == AT) begin mst[p] = 2; mcnt[p] = 0; end
          else mcnt[p] = mcnt[p] + 1;
        end
      end else begin
        if (tx[p]) mcnt[p] = 0;
        else if (tk) begin
          if (mcnt[p] + 1 == UT) begin mst[p] = 0; mcnt[p] = 0; end
          else mcnt[p] = mcnt[p] + 1;
        end
      end
    end
    chk_on = 1'b1;
  end

  always @(negedge clk) begin
    if (chk_on) begin
      for (int p = 0; p < NP; p++) begin
        string rq;
        bit jab;
        jab = (mst[p] == 2);
        if (dis)               rq = "R7";
        else if (jab)          rq = "R3";
        else if (mprev[p] == 2) rq = "R6";
        else                   rq = "R4";
        check(en[p] == !jab, rq, en[p], !jab);
        check(col[p] == jab, "R5", col[p], jab);
        check(led_n[p] == !jab, "R5", led_n[p], !jab);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int s, e, e1, ejab;
    mst = '{default: 0}; mcnt = '{default: 0}; mprev = '{default: 0};
    repeat (3) @(negedge clk);
    check(en == '1 && col == '0 && led_n == '1, "R1", en, 3);
    rst = 1'b0;
    @(negedge clk);
    check(en == '1 && col == '0 && led_n == '1, "R1", en, 3);

    // R2/R3: cut-off edge over every tick phase; R8 with the other port quiet.
    for (int off = 0; off < 2 * P; off++) begin
      tx = '0; dis = 1'b1;
      @(negedge clk);
      dis = 1'b0;
      repeat (off) @(negedge clk);
      tx[0] = 1'b1;
      s = k + 1;
      for (int w = 0; w < 100 && en[0]; w++) @(negedge clk);
      e = k;
      e1 = s + 1;
      while ((e1 - 1) % P != 0) e1++;
      ejab = e1 + (AT - 1) * P;
      check(e == ejab, "R2", e, ejab);
      check(en[1] == 1'b1 && col[1] == 1'b0, "R8", en[1], 1);
      tx[0] = 1'b0;
      repeat (UT * P + 2) @(negedge clk);
      check(en[0] == 1'b1, "R6", en[0], 1);
    end

    // R4: bursts one clock short of the minimum cut-off never cut.
    for (int b = 0; b < 10; b++) begin
      tx[0] = 1'b1;
      repeat ((AT - 1) * P) begin
        @(negedge clk);
        check(en[0] == 1'b1, "R4", en[0], 1);
      end
      tx[0] = 1'b0;
      @(negedge clk);
    end

    // R6: a single active clock restarts the quiet count.
    tx[0] = 1'b1;
    repeat (AT * P + 2) @(negedge clk);
    tx[0] = 1'b0;
    repeat ((UT - 1) * P) @(negedge clk);
    tx[0] = 1'b1;
    @(negedge clk);
    tx[0] = 1'b0;
    repeat ((UT - 1) * P) @(negedge clk);
    check(en[0] == 1'b0, "R6", en[0], 0);
    repeat (2 * P) @(negedge clk);
    check(en[0] == 1'b1, "R6", en[0], 1);

    // R7: disable releases a cut-off port and blocks timing.
    tx = '1;
    repeat (AT * P + 2) @(negedge clk);
    check(en == '0, "R3", en, 0);
    dis = 1'b1;
    repeat (AT * P * 3) @(negedge clk);
    check(en == '1, "R7", en, 3);
    dis = 1'b0;
    tx = '0;
    @(negedge clk);

    // Random segments over both ports and the disable input.
    for (int seg = 0; seg < 3000; seg++) begin
      int len;
      len = 1 + ($urandom % 20);
      tx  = NP'($urandom);
      dis = (($urandom % 16) == 0);
      repeat (len) @(negedge clk);
    end
    tx = '0; dis = 1'b0;
    repeat (UT * P + 4) @(negedge clk);
    check(en == '1, "R6", en, 3);
    finish_up();
  end
endmodule